// File: doc/BRIEF.md
# Octave Clock Divider with Output Configuration

This block turns a fast master clock into a pair of square-wave outputs. It divides the master rate by a power of two that a 4-bit octave code selects. The main output and the auxiliary output run in antiphase. A 2-bit configuration code switches each output on or off, or stops the divider altogether. An output-enable input forces both outputs low at once, without waiting for a clock edge.

The block's input clock `clk` runs at twice the master rate, so every output edge falls on a rising edge of `clk` and the duty cycle is exactly 50%. With octave code `k`, each half period lasts `H(k) = 2^(15-k)` input cycles. The output frequency is therefore the master rate divided by `2^(15-k)`: code 15 gives the master rate itself, and code 0 gives the largest division.

A new octave code does not act at once. It is taken over at the end of the current full output period, when the counter reaches its terminal count, so no shortened pulse appears. The configuration code is registered before it is used.

Top module: `octave_clk_div`

## Requirements
- R1: While `rstN` is low, both outputs are low. The block resets to octave 0 and configuration 00. After `rstN` is released between two clock edges, `mainOut` first goes high after the 32769th rising edge, and `auxOut` is high after the first rising edge.
- R2: With octave code `k` in effect, every high run and every low run of an active output lasts exactly `2^(15-k)` clock cycles.
- R3: Octave code 15 makes an active output toggle on every rising clock edge.
- R4: Configuration 00 (`cfgCode` = 2'b00) enables both outputs, and `auxOut` is always the complement of `mainOut`.
- R5: Configuration 01 holds `mainOut` low while `auxOut` keeps toggling.
- R6: Configuration 10 holds `auxOut` low while `mainOut` keeps toggling.
- R7: Configuration 11 is power-down: both outputs stay low and the period counter is held at zero.
- R8: When the configuration leaves 11 between two clock edges, with octave `k` applied, `mainOut` goes high after the `2^(15-k)+2`th rising edge that follows.
- R9: While `outEn` is low, both outputs are low, and they go low without waiting for a clock edge.
- R10: A new octave code takes effect only when the current output period ends. The high run in progress completes at the old length, and every later run has the new length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock, twice the master rate |
| rstN | input | 1 | Asynchronous reset, active low |
| octCode | input | 4 | Octave code; half period = 2^(15-code) cycles |
| cfgCode | input | 2 | 00 both on, 01 aux only, 10 main only, 11 power-down |
| outEn | input | 1 | Asynchronous output enable, active high |
| mainOut | output | 1 | Main divided clock |
| auxOut | output | 1 | Auxiliary divided clock, antiphase to main |

## Verification
A wrong bit select or a bad terminal-count mask shows at the ports within one output period, as a run length different from `2^(15-k)`. A mistake in the octave hand-over shows as a shortened or stretched run straight after the code changes. A wrong release from power-down shows as a first rising edge that arrives early or late. A decode error in the configuration shows within two cycles, as an output that is high when it should be held low, or as two outputs that are not complements.

// File: rtl/octdiv_pkg.sv
package octdiv_pkg;
  localparam int OCT_W   = 4;
  localparam int NUM_OCT = 1 << OCT_W;
  localparam int CNT_W   = NUM_OCT;

  typedef enum logic [1:0] {
    CFG_BOTH = 2'b00,
    CFG_AUX  = 2'b01,
    CFG_MAIN = 2'b10,
    CFG_OFF  = 2'b11
  } cfg_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             hold;
    logic [OCT_W-1:0] tapIdx;
  } ctrl_s;
endpackage

// File: rtl/octdiv_ctrl.sv
module octdiv_ctrl
  import octdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [OCT_W-1:0] octCode,
  input  logic [1:0]       cfgCode,
  input  logic             tcIn,
  output ctrl_s            ctrl,
  output logic             mainEn,
  output logic             auxEn
);
  cfg_e             cfgQ;
  logic [OCT_W-1:0] activeOct;
  logic             pd;

  assign pd = (cfgQ == CFG_OFF);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ      <= CFG_BOTH;
      activeOct <= '0;
    end else begin
      cfgQ <= cfg_e'(cfgCode);
      if (pd || tcIn) activeOct <= octCode;
    end
  end

  always_comb begin
    ctrl.hold   = pd;
    ctrl.tapIdx = OCT_W'(NUM_OCT - 1) - activeOct;
    mainEn      = (cfgQ == CFG_BOTH) || (cfgQ == CFG_MAIN);
    auxEn       = (cfgQ == CFG_BOTH) || (cfgQ == CFG_AUX);
  end

  // R10
  oct_switch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activeOct != $past(activeOct)) |-> $past(tcIn || pd));
endmodule

// File: rtl/octdiv_path.sv
module octdiv_path
  import octdiv_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  ctrl_s ctrl,
  output logic  tcOut,
  output logic  phaseQ,
  output logic  auxQ
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;

  // bit i belongs to the current period when i <= tap index
  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign mask[i] = (i <= int'(ctrl.tapIdx));
  end

  assign tcOut = &(cnt | ~mask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      phaseQ <= 1'b0;
      auxQ   <= 1'b0;
    end else if (ctrl.hold) begin
      cnt    <= '0;
      phaseQ <= 1'b0;
      auxQ   <= 1'b0;
    end else begin
      cnt    <= tcOut ? '0 : cnt + 1'b1;
      phaseQ <= cnt[ctrl.tapIdx];
      auxQ   <= ~cnt[ctrl.tapIdx];
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cnt & ~mask) == '0);

  // R7
  pd_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.hold |=> (cnt == '0) && !phaseQ);
endmodule

// File: rtl/octave_clk_div.sv
module octave_clk_div
  import octdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [OCT_W-1:0] octCode,
  input  logic [1:0]       cfgCode,
  input  logic             outEn,
  output logic             mainOut,
  output logic             auxOut
);
  ctrl_s ctrl;
  logic  tc, phaseQ, auxQ, mainEn, auxEn;

  octdiv_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .octCode(octCode), .cfgCode(cfgCode),
    .tcIn(tc), .ctrl(ctrl), .mainEn(mainEn), .auxEn(auxEn)
  );

  octdiv_path u_path (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .tcOut(tc), .phaseQ(phaseQ), .auxQ(auxQ)
  );

  assign mainOut = outEn & mainEn & phaseQ;
  assign auxOut  = outEn & auxEn & auxQ;

  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(mainOut && auxOut));
endmodule

// File: tb/sim_octave_clk_div.sv
module sim_octave_clk_div;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] octCode = 4'd0;
  logic [1:0] cfgCode = 2'd0;
  logic       outEn = 1'b1;
  logic       mainOut, auxOut;
  int total = 0;
  int bad = 0;
  bit finished = 0;
  int curOct = 0;

  octave_clk_div u0 (.clk(clk), .rstN(rstN), .octCode(octCode),
    .cfgCode(cfgCode), .outEn(outEn), .mainOut(mainOut), .auxOut(auxOut));

  always #5 clk = ~clk;

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int halfOf(int oct);
    return 1 << (15 - oct);
  endfunction

  task automatic tick;
    @(posedge clk); #2;
  endtask

  function automatic bit pick(bit useAux);
    return useAux ? auxOut : mainOut;
  endfunction

  task automatic runLen(bit useAux, output int len);
    bit v;
    v = pick(useAux);
    len = 0;
    do begin tick; len++; end while (pick(useAux) == v && len < 70000);
  endtask

  task automatic syncRise(bit useAux);
    bit prev;
    int guard;
    prev = pick(useAux);
    guard = 0;
    tick;
    while (!(prev == 1'b0 && pick(useAux) == 1'b1) && guard < 70000) begin
      prev = pick(useAux); tick; guard++;
    end
  endtask

  task automatic setOct(int newOct);
    int w;
    w = (halfOf(newOct) > halfOf(curOct)) ? halfOf(newOct) : halfOf(curOct);
    octCode = 4'(newOct);
    repeat (4 * w + 8) tick;
    curOct = newOct;
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary;
      $finish;
    end
  end

  initial begin
    int k, len, h, oct, cfg;
    bit errMain, errAux;
    void'($urandom(32'd7321));
    // R1 reset state
    repeat (3) tick;
    check(mainOut == 0 && auxOut == 0, "R1 reset outputs", {mainOut, auxOut}, 0);
    rstN = 1'b1;
    tick;
    check(auxOut == 1, "R1 aux after first edge", auxOut, 1);
    k = 1;
    while (!mainOut && k < 40000) begin tick; k++; end
    check(k == 32769, "R1 first main rise", k, 32769);

    // R7 power-down, then R8 release
    octCode = 4'd12; cfgCode = 2'b11;
    repeat (6) tick;
    errMain = 0;
    for (int i = 0; i < 40; i++) begin tick; if (mainOut || auxOut) errMain = 1; end
    check(!errMain, "R7 outputs low in power-down", errMain, 0);
    cfgCode = 2'b00;
    k = 0;
    do begin tick; k++; end while (!mainOut && k < 1000);
    check(k == halfOf(12) + 2, "R8 first rise after power-down", k, halfOf(12) + 2);
    curOct = 12;

    // R10 faster octave mid-period
    syncRise(0);
    octCode = 4'd13;
    runLen(0, len); check(len == 8, "R10 old high run completes", len, 8);
    runLen(0, len); check(len == 4, "R10 new low run", len, 4);
    runLen(0, len); check(len == 4, "R10 new high run", len, 4);
    // R10 slower octave mid-period
    syncRise(0);
    octCode = 4'd11;
    runLen(0, len); check(len == 4, "R10 old high run completes", len, 4);
    runLen(0, len); check(len == 16, "R10 new low run", len, 16);
    runLen(0, len); check(len == 16, "R10 new high run", len, 16);
    curOct = 11;

    // R9 asynchronous force-low
    syncRise(0);
    outEn = 1'b0;
    #1;
    check(mainOut == 0 && auxOut == 0, "R9 immediate force low", {mainOut, auxOut}, 0);
    errMain = 0;
    for (int i = 0; i < 40; i++) begin tick; if (mainOut || auxOut) errMain = 1; end
    check(!errMain, "R9 held low while disabled", errMain, 0);
    outEn = 1'b1;

    // R2 R3 R4 R5 R6: directed octave 15, then random trials
    for (int t = 0; t < 26; t++) begin
      oct = (t == 0) ? 15 : 9 + int'($urandom_range(6));
      cfg = (t == 0) ? 0 : int'($urandom_range(2));
      cfgCode = 2'(cfg);
      setOct(oct);
      h = halfOf(oct);
      syncRise(cfg == 1);
      runLen(cfg == 1, len);
      check(len == h, (oct == 15) ? "R3 high run" : "R2 high run", len, h);
      runLen(cfg == 1, len);
      check(len == h, (oct == 15) ? "R3 low run" : "R2 low run", len, h);
      errMain = 0; errAux = 0;
      for (int i = 0; i < 2 * h + 2; i++) begin
        tick;
        if (cfg == 0 && auxOut != !mainOut) errAux = 1;
        if (cfg == 1 && mainOut) errMain = 1;
        if (cfg == 2 && auxOut) errAux = 1;
      end
      if (cfg == 0) check(!errAux, "R4 aux complements main", errAux, 0);
      if (cfg == 1) check(!errMain, "R5 main held low", errMain, 0);
      if (cfg == 2) check(!errAux, "R6 aux held low", errAux, 0);
    end

    finished = 1;
    summary;
    $finish;
  end
endmodule